// File: doc/BRIEF.md
# Bit-Swapping Scan Pattern Generator

This block is a low-transition pseudorandom serial source for test-per-scan built-in self-test. Its core is an n-stage external shift register with feedback polynomial x^n + x + 1. It steps once per cycle while the shift enable is high. A pair of 2:1 multiplexers conditionally exchanges the first two stages, and the last stage drives the shared select. One multiplexer output feeds the scan chain. On that stream the exchange removes about half of the bit transitions that a plain register stage would produce. The ones and zeros stay roughly balanced, so the stream still serves as a random pattern source.

The chain is loaded from a seed at any time. A zero seed would lock the register up, so it is replaced by a nonzero default. The second multiplexer output and the raw register state are also brought out so that the stream can be observed.

Top module: `bswap_scan_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the state to DEFAULT_SEED (default 7'h59). Reset has priority over every other input.
- R2: Bit 0 of state_o is stage 1, bit 1 is stage 2 and bit WIDTH-1 is stage n. On a rising edge with shift_en high and seed_load low, stage 1 takes stage 1 XOR stage n, and every other stage k takes the old value of stage k-1.
- R3: On a rising edge with seed_load high and a nonzero seed_value, the state becomes seed_value. This holds whatever the value of shift_en.
- R4: A seed_load with seed_value equal to zero sets the state to DEFAULT_SEED.
- R5: With both shift_en and seed_load low, the state keeps its value.
- R6: When stage n is 0, scan_in_o equals stage 1 and aux_o equals stage 2. When stage n is 1, scan_in_o equals stage 2 and aux_o equals stage 1.
- R7: From any nonzero seed, the state first returns to that seed after exactly 2^WIDTH-1 shifts. With WIDTH=7 this is 127 shifts.
- R8: Over one full period, a raw stage makes 2^(WIDTH-1) transitions (64 for WIDTH=7). Over the same period scan_in_o makes about half that many: between 28 and 36 for WIDTH=7.
- R9: Over one full period, the number of ones on scan_in_o is close to half the period: between 60 and 68 of the 127 samples for WIDTH=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load seed_value into the register |
| seed_value | input | WIDTH | Seed; a value of zero selects the default seed |
| shift_en | input | 1 | Advance the register by one step |
| scan_in_o | output | 1 | Low-transition serial stream for the scan chain |
| aux_o | output | 1 | Output of the companion multiplexer |
| state_o | output | WIDTH | Raw register state, stage 1 in bit 0 |

## Verification
Every cycle, the stream and the state are compared against a model computed from the stepping and swapping rules. These comparisons cover a run of shifts, shifts stalled by a low enable, loads that coincide with a shift, a zero seed and a reset during operation. Each of these separates the priority of load over shift and the hold behaviour from plain stepping. One full period from a nonzero seed distinguishes a maximal-length feedback from a shorter cycle. It also shows whether the select polarity and the choice of output stage really cut the transition count while keeping the ones balanced.

// File: rtl/bswap_scan_gen.sv
module bswap_scan_gen #(
  parameter int WIDTH = 7,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 'h59,
  parameter bit SWAP_ON_SEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_value,
  input  logic             shift_en,
  output logic             scan_in_o,
  output logic             aux_o,
  output logic [WIDTH-1:0] state_o
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] stepped;
  logic [WIDTH-1:0] seed_eff;
  logic             swap;

  assign stepped  = {state_q[TOP-1:0], state_q[0] ^ state_q[TOP]};
  assign seed_eff = (seed_value == '0) ? DEFAULT_SEED : seed_value;
  assign swap     = (state_q[TOP] == SWAP_ON_SEL);

  always_ff @(posedge clk) begin
    if (rst)            state_q <= DEFAULT_SEED;
    else if (seed_load) state_q <= seed_eff;
    else if (shift_en)  state_q <= stepped;
  end

  assign scan_in_o = swap ? state_q[0] : state_q[1];
  assign aux_o     = swap ? state_q[1] : state_q[0];
  assign state_o   = state_q;

  a_r1_nonzero: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !seed_load) |=>
      (state_q[0] == ($past(state_q[0]) ^ $past(state_q[TOP]))) &&
      (state_q[TOP:1] == $past(state_q[TOP-1:0])));

  a_r3_seed: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_value != '0) |=> state_q == $past(seed_value));

  a_r4_zero_seed: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_value == '0) |=> state_q == DEFAULT_SEED);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !seed_load) |=> $stable(state_q));

  a_r6_pair_kept: assert property (@(posedge clk) disable iff (rst)
    $countones({scan_in_o, aux_o}) == $countones(state_q[1:0]));

endmodule

// File: tb/bswap_scan_gen_bench.sv
module bswap_scan_gen_bench;
  localparam int W = 7;
  localparam logic [W-1:0] DEF = 7'h59;
  localparam int PERIOD = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seed_load = 1'b0;
  logic [W-1:0] seed_value = '0;
  logic shift_en = 1'b0;
  logic scan_in_o, aux_o;
  logic [W-1:0] state_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic         scan;
    logic         aux;
    logic [W-1:0] st;
    string        tag;
  } exp_t;

  exp_t q[$];
  logic [W-1:0] model = DEF;

  always #4 clk = ~clk;

  bswap_scan_gen #(.WIDTH(W), .DEFAULT_SEED(DEF), .SWAP_ON_SEL(1'b0)) u_bswap_scan_gen (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .shift_en(shift_en), .scan_in_o(scan_in_o), .aux_o(aux_o), .state_o(state_o));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic ld, input logic [W-1:0] sv,
                      input logic sh, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; seed_load = ld; seed_value = sv; shift_en = sh;
    if (r)       model = DEF;
    else if (ld) model = (sv == '0) ? DEF : sv;
    else if (sh) model = {model[W-2:0], model[0] ^ model[W-1]};
    e.st   = model;
    e.scan = model[W-1] ? model[1] : model[0];
    e.aux  = model[W-1] ? model[0] : model[1];
    e.tag  = tag;
    q.push_back(e);
    @(posedge clk);
    #3;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " state"}, int'(state_o), int'(e.st));
        check({e.tag, " R6 scan_in"}, int'(scan_in_o), int'(e.scan));
        check({e.tag, " R6 aux"}, int'(aux_o), int'(e.aux));
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    int raw_tr, scan_tr, ones, early;
    logic prev_raw, prev_scan;
    logic [W-1:0] seed;
    step(1'b1, 1'b0, '0, 1'b0, "R1 reset");
    step(1'b0, 1'b0, '0, 1'b0, "R5 hold after reset");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, '0, 1'b1, "R2 shift");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 7'h33, 1'b0, "R5 hold");
    step(1'b0, 1'b1, 7'h15, 1'b1, "R3 load over shift");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, '0, (i % 2) == 0, "R2 R5 mixed");
    step(1'b0, 1'b1, '0, 1'b0, "R4 zero seed");
    step(1'b0, 1'b0, '0, 1'b1, "R2 after zero seed");
    step(1'b1, 1'b1, 7'h40, 1'b1, "R1 reset priority");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0, 1'b1, "R2 shift");

    seed = 7'h2A;
    step(1'b0, 1'b1, seed, 1'b0, "R3 period seed");
    prev_raw = state_o[0]; prev_scan = scan_in_o;
    raw_tr = 0; scan_tr = 0; ones = 0; early = 0;
    for (int i = 1; i <= PERIOD; i++) begin
      step(1'b0, 1'b0, '0, 1'b1, "R7 period");
      if (state_o[0] != prev_raw) raw_tr++;
      if (scan_in_o != prev_scan) scan_tr++;
      if (scan_in_o) ones++;
      prev_raw = state_o[0]; prev_scan = scan_in_o;
      if (i < PERIOD && state_o == seed) early++;
    end
    check("R7 return to seed", int'(state_o), int'(seed));
    check("R7 no early repeat", early, 0);
    check("R8 raw transitions", raw_tr, 1 << (W - 1));
    check("R8 scan transitions in 28..36", int'(scan_tr >= 28 && scan_tr <= 36), 1);
    if (scan_tr < 28 || scan_tr > 36) $display("FAIL R8 actual=%0d expected=28..36", scan_tr);
    check("R9 ones in 60..68", int'(ones >= 60 && ones <= 68), 1);
    if (ones < 60 || ones > 68) $display("FAIL R9 actual=%0d expected=60..68", ones);

    @(posedge clk); #5;
    check("scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule